// File: doc/BRIEF.md
# Four-Buffer Zero-Copy Transmit Engine

This block gives a CPU four dedicated transmit buffers of 64 bytes each. They sit in on-chip block RAM at fixed addresses in the CPU's memory map and are not taken from general-purpose RAM. The CPU fills a buffer through a byte window. It then passes that buffer to a hardware sequencer by writing the buffer's number and byte count to a control register. From that moment the buffer belongs to the engine, and CPU accesses to it do nothing.

The sequencer serves handed-off buffers in the order they arrived. It pushes each byte to an external network controller over a byte-wide write port that has chip-select and write strobe lines. A wait input from the controller can lengthen the strobe. When a buffer's last byte has gone out, the buffer returns to the CPU and its done flag is set. The CPU can poll that flag or let it raise a level interrupt.

Because ownership is tracked per buffer, software can fill one buffer while the engine drains others.

Top module: `zc_tx_engine`

## Requirements
- R1: Byte k of buffer b is at CPU address 0x100 + 64*b + k. A write stores cpu_wdata[7:0]. A read with cpu_re returns the byte on cpu_rdata[7:0] one cycle later, with the upper bits zero.
- R2: Writing to address 0x000 hands buffer cpu_wdata[1:0] to the engine with length cpu_wdata[14:8]. A length above 64 is treated as 64. While the engine owns buffer b, status bit 4+b reads 1.
- R3: While the engine owns a buffer, CPU writes to it are ignored and CPU reads of it return 0.
- R4: A handed-off buffer is sent as bytes at offsets 0 up to length-1, in ascending order. During each write, ext_addr carries the offset and ext_data carries the stored byte.
- R5: Each byte write follows a fixed sequence. First, one cycle with ext_cs high and ext_wr low. Next, at least two cycles with ext_cs and ext_wr high. Then one cycle with ext_cs high and ext_wr low. Between bytes there is at least one cycle with ext_cs low.
- R6: A high ext_wait keeps ext_wr asserted. The strobe ends after the first cycle, from its second cycle onward, in which ext_wait is low.
- R7: Buffers are sent in the order in which they were handed off.
- R8: Status is read at address 0x001. When a buffer's last byte completes, its ownership bit clears and done bit b (status bits 3:0) sets. All status bits read 0 after reset.
- R9: A hand-off with length 0 sets done bit b at once. The buffer stays with the CPU and no external write is made.
- R10: irq is high while any done bit is set whose enable bit is set. The enable bits are bits 3:0 at address 0x002. Writing 1 to a done bit at address 0x001 clears that bit.
- R11: A hand-off of a buffer the engine already owns is ignored and sets the sticky error bit, status bit 8. Writing 1 to status bit 8 clears it.
- R12: The CPU can write and read back a buffer it owns while the engine is sending another buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 9 | CPU address: bit 8 selects the buffer window |
| cpu_we | input | 1 | CPU write enable |
| cpu_re | input | 1 | CPU read enable; data appears one cycle later |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data |
| ext_cs | output | 1 | Chip select to the external controller |
| ext_wr | output | 1 | Write strobe to the external controller |
| ext_addr | output | 6 | Byte offset being written |
| ext_data | output | 8 | Byte being written |
| ext_wait | input | 1 | Stretches the write strobe while high |
| irq | output | 1 | Level interrupt for returned buffers |

## Verification
Buffers of different lengths and byte patterns are handed off, both one at a time and as a burst of three while the first is still being sent. The burst shows whether service order follows hand-off order, and the scoreboard catches any missing, extra or reordered byte. Each test is run with ext_wait idle and again with it held for several cycles, which separates the fixed two-cycle strobe from a stretched one. Zero-length hand-offs, hand-offs of an owned buffer, writes into an owned buffer and lengths over 64 are the patterns that show whether ignored stimulus really leaves the wire, the buffer contents and the status untouched.

// File: rtl/txeng_pkg.sv
package txeng_pkg;
    localparam int NBUF      = 4;
    localparam int BUF_BYTES = 64;
    localparam int DATA_W    = 8;
    localparam int CPU_DW    = 16;
    localparam int IDX_W     = $clog2(NBUF);
    localparam int OFF_W     = $clog2(BUF_BYTES);
    localparam int LEN_W     = OFF_W + 1;
    localparam int RAM_AW    = IDX_W + OFF_W;
    localparam int CPU_AW    = RAM_AW + 1;
    localparam int LEN_LSB   = 8;
    localparam int ERR_BIT   = 2 * NBUF;

    localparam logic [CPU_AW-1:0] REG_HAND = CPU_AW'(0);
    localparam logic [CPU_AW-1:0] REG_STAT = CPU_AW'(1);
    localparam logic [CPU_AW-1:0] REG_IEN  = CPU_AW'(2);

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_SETUP, ST_STROBE, ST_HOLD
    } wire_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [LEN_W-1:0] len;
    } job_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
        return (raw > LEN_W'(BUF_BYTES)) ? LEN_W'(BUF_BYTES) : raw;
    endfunction
endpackage

// File: rtl/txeng_buf_ram.sv
module txeng_buf_ram
    import txeng_pkg::*;
#(
    parameter int AW = RAM_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_q,
    input  logic [AW-1:0] b_addr,
    output logic [DW-1:0] b_q
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        a_q <= mem[a_addr];
        b_q <= mem[b_addr];
    end
endmodule

// File: rtl/txeng_job_fifo.sv
module txeng_job_fifo
    import txeng_pkg::*;
#(
    parameter int DEPTH = NBUF
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  job_t push_job,
    input  logic pop,
    output job_t head_job,
    output logic empty,
    output logic full
);
    localparam int PW = $clog2(DEPTH);

    job_t          slot [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [PW:0]   cnt_q;

    assign empty    = (cnt_q == '0);
    assign full     = (cnt_q == (PW+1)'(DEPTH));
    assign head_job = slot[rp_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                slot[wp_q] <= push_job;
                wp_q       <= wp_q + 1'b1;
            end
            if (pop) rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + (PW+1)'(push) - (PW+1)'(pop);
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));  // R7
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);  // R7
endmodule

// File: rtl/txeng_wire_fsm.sv
module txeng_wire_fsm
    import txeng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              job_valid,
    input  job_t              job,
    output logic              job_pop,
    output logic [RAM_AW-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_q,
    output logic              ext_cs,
    output logic              ext_wr,
    output logic [OFF_W-1:0]  ext_addr,
    output logic [DATA_W-1:0] ext_data,
    input  logic              ext_wait,
    output logic              done_pulse,
    output logic [IDX_W-1:0]  done_idx
);
    wire_state_e      st_q;
    logic [IDX_W-1:0] idx_q;
    logic [OFF_W-1:0] off_q, last_q;
    logic             strb_q;

    assign job_pop    = (st_q == ST_IDLE) && job_valid;
    assign ram_addr   = {idx_q, off_q};
    assign ext_cs     = (st_q == ST_SETUP) || (st_q == ST_STROBE) || (st_q == ST_HOLD);
    assign ext_wr     = (st_q == ST_STROBE);
    assign ext_addr   = off_q;
    assign ext_data   = ram_q;
    assign done_pulse = (st_q == ST_HOLD) && (off_q == last_q);
    assign done_idx   = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            off_q  <= '0;
            last_q <= '0;
            strb_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (job_valid) begin
                    idx_q  <= job.idx;
                    last_q <= OFF_W'(job.len - LEN_W'(1));
                    off_q  <= '0;
                    st_q   <= ST_FETCH;
                end
                ST_FETCH: st_q <= ST_SETUP;
                ST_SETUP: begin
                    strb_q <= 1'b0;
                    st_q   <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (strb_q && !ext_wait) st_q <= ST_HOLD;
                    else                     strb_q <= 1'b1;
                end
                ST_HOLD: begin
                    if (off_q == last_q) begin
                        st_q <= ST_IDLE;
                    end else begin
                        off_q <= off_q + 1'b1;
                        st_q  <= ST_FETCH;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_wr) |-> ($past(ext_cs) && ext_cs));  // R5
    AST_STROBE_MIN_TWO: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_wr) |=> ext_wr);  // R5
    AST_WAIT_HOLDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (ext_wr && ext_wait) |=> ext_wr);  // R6
    AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_wr) |-> ext_cs);  // R5
endmodule

// File: rtl/zc_tx_engine.sv
module zc_tx_engine
    import txeng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic              cpu_re,
    input  logic [CPU_DW-1:0] cpu_wdata,
    output logic [CPU_DW-1:0] cpu_rdata,
    output logic              ext_cs,
    output logic              ext_wr,
    output logic [OFF_W-1:0]  ext_addr,
    output logic [DATA_W-1:0] ext_data,
    input  logic              ext_wait,
    output logic              irq
);
    logic [NBUF-1:0] own_q, done_q, ien_q;
    logic            err_q;

    logic              in_window, buf_wr, hand_wr, stat_wr, ien_wr;
    logic [IDX_W-1:0]  win_idx, hand_idx, eng_idx;
    logic [LEN_W-1:0]  hand_len;
    logic              hand_ok, push, eng_done;
    job_t              head_job;
    logic              fifo_empty, fifo_full, pop;
    logic [RAM_AW-1:0] eng_raddr;
    logic [DATA_W-1:0] qa, qb;
    logic              rd_win_q, rd_blk_q;
    logic [CPU_DW-1:0] rd_reg_q;

    assign in_window = cpu_addr[CPU_AW-1];
    assign win_idx   = cpu_addr[RAM_AW-1:OFF_W];
    assign buf_wr    = cpu_we && in_window && !own_q[win_idx];
    assign hand_wr   = cpu_we && (cpu_addr == REG_HAND);
    assign stat_wr   = cpu_we && (cpu_addr == REG_STAT);
    assign ien_wr    = cpu_we && (cpu_addr == REG_IEN);
    assign hand_idx  = cpu_wdata[IDX_W-1:0];
    assign hand_len  = clamp_len(cpu_wdata[LEN_LSB +: LEN_W]);
    assign hand_ok   = hand_wr && !own_q[hand_idx];
    assign push      = hand_ok && (hand_len != '0);

    txeng_buf_ram u_ram (
        .clk     (clk),
        .a_we    (buf_wr),
        .a_addr  (cpu_addr[RAM_AW-1:0]),
        .a_wdata (cpu_wdata[DATA_W-1:0]),
        .a_q     (qa),
        .b_addr  (eng_raddr),
        .b_q     (qb)
    );

    txeng_job_fifo u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_job ('{idx: hand_idx, len: hand_len}),
        .pop      (pop),
        .head_job (head_job),
        .empty    (fifo_empty),
        .full     (fifo_full)
    );

    txeng_wire_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .job_valid  (!fifo_empty),
        .job        (head_job),
        .job_pop    (pop),
        .ram_addr   (eng_raddr),
        .ram_q      (qb),
        .ext_cs     (ext_cs),
        .ext_wr     (ext_wr),
        .ext_addr   (ext_addr),
        .ext_data   (ext_data),
        .ext_wait   (ext_wait),
        .done_pulse (eng_done),
        .done_idx   (eng_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= '0;
            done_q <= '0;
            ien_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            logic [NBUF-1:0] own_n, done_n;
            own_n  = own_q;
            done_n = done_q;
            if (stat_wr) done_n = done_n & ~cpu_wdata[NBUF-1:0];
            if (eng_done) begin
                own_n[eng_idx]  = 1'b0;
                done_n[eng_idx] = 1'b1;
            end
            if (push) own_n[hand_idx] = 1'b1;
            if (hand_ok && (hand_len == '0)) done_n[hand_idx] = 1'b1;
            own_q  <= own_n;
            done_q <= done_n;
            if (ien_wr) ien_q <= cpu_wdata[NBUF-1:0];
            if (hand_wr && own_q[hand_idx])       err_q <= 1'b1;
            else if (stat_wr && cpu_wdata[ERR_BIT]) err_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_win_q <= 1'b0;
            rd_blk_q <= 1'b0;
            rd_reg_q <= '0;
        end else if (cpu_re) begin
            rd_win_q <= in_window;
            rd_blk_q <= own_q[win_idx];
            unique case (cpu_addr)
                REG_STAT: rd_reg_q <= CPU_DW'({err_q, own_q, done_q});
                REG_IEN:  rd_reg_q <= CPU_DW'(ien_q);
                default:  rd_reg_q <= '0;
            endcase
        end
    end

    assign cpu_rdata = rd_win_q ? (rd_blk_q ? '0 : CPU_DW'(qa)) : rd_reg_q;
    assign irq       = |(done_q & ien_q);

    AST_DONE_RETURNS_BUFFER: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> (!own_q[$past(eng_idx)] && done_q[$past(eng_idx)]));  // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !(stat_wr && cpu_wdata[ERR_BIT])) |=> err_q);  // R11
    AST_WIRE_ONLY_WHEN_OWNED: assert property (@(posedge clk) disable iff (rst)
        ext_cs |-> (own_q != '0));  // R3
    AST_ZERO_LEN_NO_CLAIM: assert property (@(posedge clk) disable iff (rst)
        (hand_ok && (hand_len == '0) && !own_q[hand_idx]) |=> !own_q[$past(hand_idx)]);  // R9
endmodule

// File: tb/zc_tx_engine_tb.sv
module zc_tx_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic        cpu_re = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        ext_cs, ext_wr, ext_wait;
    logic [5:0]  ext_addr;
    logic [7:0]  ext_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int wr_count = 0;
    int exp_strobe = 2;
    int wait_len = 0;
    bit [13:0] sb[$];

    always #4 clk = ~clk;

    zc_tx_engine u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ext_cs(ext_cs), .ext_wr(ext_wr),
        .ext_addr(ext_addr), .ext_data(ext_data), .ext_wait(ext_wait), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every strobe, measures strobe width, drives wait
    initial ext_wait = 1'b0;
    always @(negedge clk) begin : mon
        static bit prev_wr = 1'b0;
        static bit prev_cs = 1'b0;
        static int scnt = 0;
        if (ext_wr && !prev_wr) begin
            wr_count++;
            check(prev_cs, "R5 setup cycle before strobe", prev_cs, 1);
            if (sb.size() == 0) begin
                check(1'b0, "R4 unexpected byte write", {ext_addr, ext_data}, -1);
            end else begin
                bit [13:0] e;
                e = sb.pop_front();
                check({ext_addr, ext_data} == e, "R4 byte/offset on wire", {ext_addr, ext_data}, e);
            end
        end
        if (ext_wr) begin
            scnt++;
            check(ext_cs, "R5 cs during strobe", ext_cs, 1);
        end
        if (!ext_wr && prev_wr) begin
            check(scnt == exp_strobe, "R6 strobe width", scnt, exp_strobe);
            check(ext_cs, "R5 hold cycle after strobe", ext_cs, 1);
            scnt = 0;
        end
        ext_wait = ext_wr && (scnt < wait_len);
        prev_wr = ext_wr;
        prev_cs = ext_cs;
    end

    task automatic cpu_write(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [8:0] a, output logic [15:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_re = 1'b1;
        @(negedge clk);
        cpu_re = 1'b0;
        d = cpu_rdata;
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'(seed + 7 * k);
    endfunction

    task automatic fill(input int b, input int n, input int seed);
        for (int k = 0; k < n; k++) cpu_write(9'(256 + 64 * b + k), 16'(pat(seed, k)));
    endtask

    // driver: queues the expected bytes, then hands the buffer off
    task automatic send(input int b, input int n, input int seed);
        int m;
        m = (n > 64) ? 64 : n;
        cpu_write(9'd1, 16'(1 << b));
        for (int k = 0; k < m; k++) sb.push_back({6'(k), pat(seed, k)});
        cpu_write(9'd0, {1'b0, 7'(n), 6'd0, 2'(b)});
    endtask

    task automatic wait_done(input int b);
        logic [15:0] s;
        for (int i = 0; i < 3000; i++) begin
            cpu_read(9'd1, s);
            if (s[b]) break;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [15:0] r;
        int c0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // reset state
        cpu_read(9'd1, r);
        check(r == 16'd0, "R8 status after reset", r, 0);
        check(irq == 1'b0 && ext_cs == 1'b0, "R10 irq/cs after reset", {irq, ext_cs}, 0);

        // R1: window write and read back
        fill(1, 5, 17);
        cpu_read(9'(256 + 64 + 3), r);
        check(r == 16'(pat(17, 3)), "R1 buffer readback", r, pat(17, 3));

        // R2/R3/R4/R8: single buffer
        send(1, 5, 17);
        cpu_read(9'd1, r);
        check(r[5] == 1'b1, "R2 owned after hand-off", r[5], 1);
        cpu_read(9'(256 + 64 + 2), r);
        check(r == 16'd0, "R3 read of owned buffer", r, 0);
        cpu_write(9'(256 + 64), 16'h00EE);
        wait_done(1);
        cpu_read(9'd1, r);
        check(r[1] == 1'b1 && r[5] == 1'b0, "R8 done set and ownership back", r, 2);
        cpu_read(9'(256 + 64), r);
        check(r == 16'(pat(17, 0)), "R3 write to owned buffer ignored", r, pat(17, 0));

        // R7/R12: burst hand-off, fill during transmit
        fill(3, 40, 3);
        fill(0, 4, 90);
        fill(2, 3, 200);
        send(3, 40, 3);
        fill(1, 10, 55);
        cpu_read(9'd1, r);
        check(r[7] == 1'b1, "R12 buffer 3 still sending during fill", r[7], 1);
        cpu_read(9'(256 + 64 + 9), r);
        check(r == 16'(pat(55, 9)), "R12 fill while other buffer sends", r, pat(55, 9));
        send(0, 4, 90);
        send(2, 3, 200);
        wait_done(2);
        check(sb.size() == 0, "R7 all queued buffers drained in order", sb.size(), 0);

        // R6: stretched strobe
        wait_len = 5; exp_strobe = 5;
        send(0, 2, 90);
        wait_done(0);
        repeat (4) @(negedge clk);
        wait_len = 0; exp_strobe = 2;
        check(sb.size() == 0, "R6 stretched transfers complete", sb.size(), 0);

        // R9: zero length
        c0 = wr_count;
        send(2, 0, 0);
        cpu_read(9'd1, r);
        check(r[2] == 1'b1 && r[6] == 1'b0, "R9 zero length returns at once", r, 4);
        repeat (20) @(negedge clk);
        check(wr_count == c0, "R9 no external write", wr_count, c0);

        // R11: duplicate hand-off
        fill(0, 8, 33);
        send(0, 8, 33);
        cpu_write(9'd0, {1'b0, 7'd3, 8'd0});
        cpu_read(9'd1, r);
        check(r[8] == 1'b1, "R11 error set", r[8], 1);
        wait_done(0);
        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R11 duplicate ignored", sb.size(), 0);
        cpu_read(9'd1, r);
        check(r[8] == 1'b1, "R11 error is sticky", r[8], 1);
        cpu_write(9'd1, 16'h0100);
        cpu_read(9'd1, r);
        check(r[8] == 1'b0, "R11 error cleared", r[8], 0);

        // R10: interrupt
        cpu_write(9'd1, 16'h000F);
        cpu_write(9'd2, 16'h0002);
        send(3, 0, 0);
        cpu_read(9'd1, r);
        check(r[3] == 1'b1 && irq == 1'b0, "R10 disabled done leaves irq low", irq, 0);
        send(1, 1, 55);
        wait_done(1);
        check(irq == 1'b1, "R10 irq on enabled done", irq, 1);
        cpu_write(9'd1, 16'h0002);
        @(negedge clk);
        check(irq == 1'b0, "R10 irq cleared by W1C", irq, 0);

        // R2: length clamp
        fill(2, 64, 11);
        send(2, 100, 11);
        wait_done(2);
        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R2 length above 64 sends 64 bytes", sb.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule